// File: doc/BRIEF.md
# Descriptor Ring DMA Pipe

This block runs one DMA pipe that walks a circular ring of 8-byte descriptors kept in external memory. Software programs the ring base address and ring size, enables the pipe, and then advances a producer byte offset to hand over work. The pipe reads the descriptor at the current consumer offset through a memory read port. It passes the buffer address and byte count to an external data mover, waits for the mover to finish, and then steps the consumer offset forward by one descriptor, wrapping at the ring size. Software can read the consumer offset back to see how far the pipe has got.

Flag bits in each descriptor decide which event pulses the pipe raises when that descriptor completes: interrupt request, end of transfer, end of block. A fence flag is passed to the mover as a request to wait for write completion. A mover error parks the pipe in a fault state with the error event held high until software resets the pipe. The control flow is one state machine. IDLE waits for work. FETCH reads the descriptor. MOVE waits on the mover. RETIRE advances the consumer and pulses events. FAULT holds after an error. Its transitions are:
- IDLE to FETCH when the pipe is enabled, not halted and the ring is not empty.
- FETCH to MOVE on a read acknowledge with a non-zero count.
- FETCH to RETIRE on a read acknowledge with a zero count.
- MOVE to RETIRE on mover done.
- MOVE to FAULT on mover error.
- RETIRE to IDLE always.
- Any state to IDLE while the pipe reset is held.

Top module: `ringdma_pipe`

## Requirements
- R1: After rst_n, or after writing 1 and then 0 to the reset register (offset 0x04, bit 0), the control, halt, base, producer and consumer registers read 0, the size register reads 32768 and ev_err is low. While reset is held at 1, writes to the other registers are dropped and they read their defaults.
- R2: A descriptor is fetched as one 64-bit read at base+consumer. Bits 31:0 are the buffer address, bits 47:32 the byte count and bits 63:48 the flags. The mover receives that address and count.
- R3: Writing the producer register (offset 0x14, low 3 bits dropped) starts work. Descriptors are processed until consumer equals producer, and no fetch is issued while they are equal.
- R4: The consumer register (offset 0x18, low 16 bits) holds the byte offset of the descriptor in progress. It advances by 8 when that descriptor completes.
- R5: The consumer offset wraps to 0 when it reaches the ring size (offset 0x10).
- R6: Writing 1 to the halt register (offset 0x08, bit 0) stops new fetches with the consumer unchanged. Writing 0 resumes from the same offset.
- R7: In the control register (offset 0x00), bit 1 enables the pipe and no fetch occurs while it is 0. Bit 3 drives mv_to_mem (1 means peripheral to memory). Bit 5 (system mode) is stored and read back.
- R8: When a descriptor completes, flag bit 15 pulses ev_desc, bit 14 pulses ev_eot and bit 13 pulses ev_eob, each for one cycle. Flag bit 12 drives mv_fence during that descriptor's mover request.
- R9: A descriptor with a byte count of 0 completes without any mover request.
- R10: A mover error holds ev_err high, leaves the consumer on the failing descriptor, and blocks further fetches until a pipe reset.
- R11: The low 3 bits written to the base register (offset 0x0C) are ignored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Descriptor contents |
| mv_req | output | 1 | Data mover request |
| mv_addr | output | 32 | Buffer address for the mover |
| mv_len | output | 16 | Byte count for the mover |
| mv_to_mem | output | 1 | Transfer direction, 1 = peripheral to memory |
| mv_fence | output | 1 | Mover waits for write completion |
| mv_done | input | 1 | Mover finished |
| mv_err | input | 1 | Mover failed |
| ev_desc | output | 1 | Descriptor interrupt event pulse |
| ev_eot | output | 1 | End of transfer event pulse |
| ev_eob | output | 1 | End of block event pulse |
| ev_err | output | 1 | Error event, held until pipe reset |

## Verification
The bench drives the ring past its end with a 32-byte ring. A pipe that compared against the wrong bound, or never wrapped, would fetch from past the ring and its fetch addresses would not match the scoreboard. It writes a zero-count descriptor, which a careless design would hand to the mover as an empty request. It halts and disables the pipe with work pending, where a wrong design would keep fetching or lose its place. It injects a mover error and then offers more work, which must be refused until a pipe reset; a design that recovered on its own would issue an unexpected fetch. Event flags are varied per descriptor so that a swapped or stuck flag shows up as a mismatched event.

// File: rtl/ringdma_pkg.sv
package ringdma_pkg;
    localparam int DESC_BYTES = 8;

    // Word layout: flags in the top half-word, count below it, address low.
    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] count;
        logic [31:0] addr;
    } ring_desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_MOVE,
        ST_RETIRE,
        ST_FAULT
    } pipe_state_t;

    localparam int FLG_IRQ   = 15;
    localparam int FLG_EOT   = 14;
    localparam int FLG_EOB   = 13;
    localparam int FLG_FENCE = 12;

    localparam int CTL_EN  = 1;
    localparam int CTL_DIR = 3;
    localparam int CTL_SYS = 5;

    // Register word indices (byte offset / 4).
    localparam int RG_CTRL  = 0;
    localparam int RG_RESET = 1;
    localparam int RG_HALT  = 2;
    localparam int RG_BASE  = 3;
    localparam int RG_SIZE  = 4;
    localparam int RG_PROD  = 5;
    localparam int RG_CONS  = 6;
endpackage

// File: rtl/ringdma_regs.sv
module ringdma_regs
    import ringdma_pkg::*;
#(
    parameter int RA_W     = 5,
    parameter int OFS_W    = 16,
    parameter int AW       = 32,
    parameter int DEF_SIZE = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [OFS_W-1:0] cons_i,
    output logic             clr_o,
    output logic             en_o,
    output logic             dir_o,
    output logic             halt_o,
    output logic [AW-1:0]    base_o,
    output logic [OFS_W-1:0] size_o,
    output logic [OFS_W-1:0] prod_o
);
    localparam int IDX_W = RA_W - 2;
    localparam logic [5:0] CTL_MASK = 6'(1 << CTL_EN) | 6'(1 << CTL_DIR) | 6'(1 << CTL_SYS);

    logic [IDX_W-1:0] idx;
    logic             rst_q;
    logic [5:0]       ctrl_q;
    logic             halt_q;
    logic [AW-1:0]    base_q;
    logic [OFS_W-1:0] size_q;
    logic [OFS_W-1:0] prod_q;
    logic             unused_addr_bits;

    assign idx              = reg_addr[RA_W-1:2];
    assign unused_addr_bits = ^reg_addr[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q  <= 1'b0;
            ctrl_q <= '0;
            halt_q <= 1'b0;
            base_q <= '0;
            size_q <= OFS_W'(DEF_SIZE);
            prod_q <= '0;
        end else begin
            if (reg_wr && idx == IDX_W'(RG_RESET))
                rst_q <= reg_wdata[0];
            if (rst_q) begin
                ctrl_q <= '0;
                halt_q <= 1'b0;
                base_q <= '0;
                size_q <= OFS_W'(DEF_SIZE);
                prod_q <= '0;
            end else if (reg_wr) begin
                case (idx)
                    IDX_W'(RG_CTRL): ctrl_q <= reg_wdata[5:0] & CTL_MASK;
                    IDX_W'(RG_HALT): halt_q <= reg_wdata[0];
                    IDX_W'(RG_BASE): base_q <= {reg_wdata[AW-1:3], 3'b000};
                    IDX_W'(RG_SIZE): size_q <= reg_wdata[OFS_W-1:0];
                    IDX_W'(RG_PROD): prod_q <= {reg_wdata[OFS_W-1:3], 3'b000};
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (idx)
            IDX_W'(RG_CTRL):  reg_rdata = 32'(ctrl_q);
            IDX_W'(RG_RESET): reg_rdata = 32'(rst_q);
            IDX_W'(RG_HALT):  reg_rdata = 32'(halt_q);
            IDX_W'(RG_BASE):  reg_rdata = 32'(base_q);
            IDX_W'(RG_SIZE):  reg_rdata = 32'(size_q);
            IDX_W'(RG_PROD):  reg_rdata = 32'(prod_q);
            IDX_W'(RG_CONS):  reg_rdata = 32'(cons_i);
            default:          reg_rdata = '0;
        endcase
    end

    assign clr_o  = rst_q;
    assign en_o   = ctrl_q[CTL_EN];
    assign dir_o  = ctrl_q[CTL_DIR];
    assign halt_o = halt_q;
    assign base_o = base_q;
    assign size_o = size_q;
    assign prod_o = prod_q;

    // While the pipe reset is held, writes other than to the reset register are dropped.
    AST_HELD_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q && $past(rst_q)) |-> (prod_q == '0 && base_q == '0)) // R1
        else $error("pipe reset did not hold defaults");
endmodule

// File: rtl/ringdma_fsm.sv
module ringdma_fsm
    import ringdma_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             halt_i,
    input  logic [AW-1:0]    base_i,
    input  logic [OFS_W-1:0] size_i,
    input  logic [OFS_W-1:0] prod_i,
    output logic [OFS_W-1:0] cons_o,
    output logic             mem_req_o,
    output logic [AW-1:0]    mem_addr_o,
    input  logic             mem_ack_i,
    input  logic [63:0]      mem_rdata_i,
    output logic             mv_req_o,
    output logic [31:0]      mv_addr_o,
    output logic [15:0]      mv_len_o,
    output logic             mv_fence_o,
    input  logic             mv_done_i,
    input  logic             mv_err_i,
    output logic             ev_desc_o,
    output logic             ev_eot_o,
    output logic             ev_eob_o,
    output logic             ev_err_o
);
    pipe_state_t      state_q, state_d;
    ring_desc_t       desc_q, fetched;
    logic [OFS_W-1:0] cons_q;
    logic [OFS_W:0]   cons_step;
    logic [OFS_W-1:0] cons_next;
    logic             has_work;
    logic             unused_flag_bits;

    assign fetched          = ring_desc_t'(mem_rdata_i);
    assign has_work         = en_i && !halt_i && (cons_q != prod_i);
    assign cons_step        = {1'b0, cons_q} + (OFS_W+1)'(DESC_BYTES);
    assign cons_next        = (cons_step >= {1'b0, size_i}) ? '0 : cons_step[OFS_W-1:0];
    assign unused_flag_bits = ^desc_q.flags[11:0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (has_work) state_d = ST_FETCH;
            ST_FETCH:  if (mem_ack_i) state_d = (fetched.count == '0) ? ST_RETIRE : ST_MOVE;
            ST_MOVE:   if (mv_err_i) state_d = ST_FAULT;
                       else if (mv_done_i) state_d = ST_RETIRE;
            ST_RETIRE: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_FAULT;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= ST_IDLE;
        else if (clr_i)  state_q <= ST_IDLE;
        else             state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cons_q <= '0;
            desc_q <= '0;
        end else if (clr_i) begin
            cons_q <= '0;
            desc_q <= '0;
        end else begin
            if (state_q == ST_FETCH && mem_ack_i) desc_q <= fetched;
            if (state_q == ST_RETIRE)             cons_q <= cons_next;
        end
    end

    always_comb begin
        mem_req_o  = (state_q == ST_FETCH);
        mem_addr_o = base_i + AW'(cons_q);
        mv_req_o   = (state_q == ST_MOVE);
        mv_addr_o  = desc_q.addr;
        mv_len_o   = desc_q.count;
        mv_fence_o = (state_q == ST_MOVE) && desc_q.flags[FLG_FENCE];
        ev_desc_o  = (state_q == ST_RETIRE) && desc_q.flags[FLG_IRQ];
        ev_eot_o   = (state_q == ST_RETIRE) && desc_q.flags[FLG_EOT];
        ev_eob_o   = (state_q == ST_RETIRE) && desc_q.flags[FLG_EOB];
        ev_err_o   = (state_q == ST_FAULT);
    end

    assign cons_o = cons_q;

    AST_NO_FETCH_WITHOUT_WORK: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        (state_q == ST_IDLE && !has_work) |=> !mem_req_o) // R3
        else $error("fetch issued with no work");

    AST_CONS_STEP: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        !$stable(cons_q) |-> (cons_q == '0 || 32'(cons_q) == 32'($past(cons_q)) + DESC_BYTES)) // R4
        else $error("consumer moved by other than one descriptor");

    AST_ZERO_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        (state_q == ST_FETCH && mem_ack_i && fetched.count == '0) |=> !mv_req_o) // R9
        else $error("zero-count descriptor reached the mover");

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        ev_err_o |=> (ev_err_o && !mem_req_o)) // R10
        else $error("pipe left the fault state without reset");

    AST_ONE_PORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && mv_req_o)) // R2
        else $error("fetch and move requested together");

    AST_EVENT_PULSE: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        (ev_desc_o || ev_eot_o || ev_eob_o) |=> !(ev_desc_o || ev_eot_o || ev_eob_o)) // R8
        else $error("completion event longer than one cycle");
endmodule

// File: rtl/ringdma_pipe.sv
module ringdma_pipe
    import ringdma_pkg::*;
#(
    parameter int RA_W     = 5,
    parameter int OFS_W    = 16,
    parameter int AW       = 32,
    parameter int DEF_SIZE = 32768
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_ack,
    input  logic [63:0]     mem_rdata,
    output logic            mv_req,
    output logic [31:0]     mv_addr,
    output logic [15:0]     mv_len,
    output logic            mv_to_mem,
    output logic            mv_fence,
    input  logic            mv_done,
    input  logic            mv_err,
    output logic            ev_desc,
    output logic            ev_eot,
    output logic            ev_eob,
    output logic            ev_err
);
    logic             clr, en, dir, halt;
    logic [AW-1:0]    base;
    logic [OFS_W-1:0] size, prod, cons;

    ringdma_regs #(.RA_W(RA_W), .OFS_W(OFS_W), .AW(AW), .DEF_SIZE(DEF_SIZE)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cons_i(cons),
        .clr_o(clr), .en_o(en), .dir_o(dir), .halt_o(halt),
        .base_o(base), .size_o(size), .prod_o(prod)
    );

    ringdma_fsm #(.OFS_W(OFS_W), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(en), .halt_i(halt),
        .base_i(base), .size_i(size), .prod_i(prod), .cons_o(cons),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
        .mem_rdata_i(mem_rdata), .mv_req_o(mv_req), .mv_addr_o(mv_addr),
        .mv_len_o(mv_len), .mv_fence_o(mv_fence), .mv_done_i(mv_done),
        .mv_err_i(mv_err), .ev_desc_o(ev_desc), .ev_eot_o(ev_eot),
        .ev_eob_o(ev_eob), .ev_err_o(ev_err)
    );

    assign mv_to_mem = dir;
endmodule

// File: tb/ringdma_pipe_bench.sv
module ringdma_pipe_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_CTRL = 5'h00, A_RST = 5'h04, A_HALT = 5'h08,
                           A_BASE = 5'h0C, A_SIZE = 5'h10, A_PROD = 5'h14, A_CONS = 5'h18;

    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0;
    logic [4:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        mem_req, mem_ack = 0;
    logic [31:0] mem_addr;
    logic [63:0] mem_rdata = 0;
    logic        mv_req, mv_to_mem, mv_fence, mv_done = 0, mv_err = 0;
    logic [31:0] mv_addr;
    logic [15:0] mv_len;
    logic        ev_desc, ev_eot, ev_eob, ev_err;

    int n_chk = 0, n_fail = 0;
    bit err_inject = 0;
    logic [63:0] dmem [0:63];
    logic [31:0] q_fetch [$];
    logic [49:0] q_move  [$];
    logic [2:0]  q_ev    [$];

    ringdma_pipe u_ringdma_pipe (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_to_mem(mv_to_mem),
        .mv_fence(mv_fence), .mv_done(mv_done), .mv_err(mv_err),
        .ev_desc(ev_desc), .ev_eot(ev_eot), .ev_eob(ev_eob), .ev_err(ev_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (60) @(negedge clk);
    endtask

    // Driver: place a descriptor and push what the pipe must do with it.
    task automatic put_desc(input logic [31:0] base, input int slot, input logic [31:0] a,
                            input logic [15:0] n, input logic [15:0] f, input bit dir,
                            input bit fails);
        dmem[slot] = {f, n, a};
        q_fetch.push_back(base + 32'(slot * 8));
        if (n != 0) q_move.push_back({dir, f[12], n, a});
        if (!fails && (f[15] || f[14] || f[13])) q_ev.push_back({f[15], f[14], f[13]});
    endtask

    // Monitor and responders, all at the falling edge.
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            if (q_fetch.size() == 0) chk("R3 unexpected fetch", {32'h0, mem_addr}, 64'hFFFF_FFFF);
            else chk("R2/R5 fetch address", {32'h0, mem_addr}, {32'h0, q_fetch.pop_front()});
            mem_rdata <= dmem[mem_addr[8:3]];
            mem_ack   <= 1;
        end else mem_ack <= 0;

        if (mv_req && !mv_done && !mv_err) begin
            if (q_move.size() == 0) chk("R9 unexpected mover request", {14'h0, mv_to_mem, mv_fence, mv_len, mv_addr}, '1);
            else chk("R2/R7/R8 mover request", {14'h0, mv_to_mem, mv_fence, mv_len, mv_addr},
                     {14'h0, q_move.pop_front()});
            if (err_inject) mv_err <= 1; else mv_done <= 1;
        end else begin
            mv_done <= 0; mv_err <= 0;
        end

        if (ev_desc || ev_eot || ev_eob) begin
            if (q_ev.size() == 0) chk("R8 unexpected event", {61'h0, ev_desc, ev_eot, ev_eob}, '1);
            else chk("R8 event flags", {61'h0, ev_desc, ev_eot, ev_eob}, {61'h0, q_ev.pop_front()});
        end
    end

    task automatic chk_drained(input string tag);
        chk({tag, " fetch queue drained"}, 64'(q_fetch.size()), 0);
        chk({tag, " move queue drained"},  64'(q_move.size()), 0);
        chk({tag, " event queue drained"}, 64'(q_ev.size()), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 64; i++) dmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(A_CONS, v); chk("R1 consumer after reset", v, 0);
        rd(A_SIZE, v); chk("R1 size after reset", v, 32768);
        rd(A_CTRL, v); chk("R1 control after reset", v, 0);
        chk("R1 error low after reset", ev_err, 0);
        chk("R3 no fetch after reset", mem_req, 0);

        // R11 base alignment, R7 control readback
        wr(A_BASE, 32'h0000_1003);
        rd(A_BASE, v); chk("R11 base low bits dropped", v, 32'h1000);
        wr(A_CTRL, 32'h22);
        rd(A_CTRL, v); chk("R7 control readback", v, 32'h22);

        // R2/R3/R4/R8 basic run of three descriptors
        put_desc(32'h1000, 0, 32'hA000, 16'd64, 16'h8000, 0, 0);
        put_desc(32'h1000, 1, 32'hB000, 16'd16, 16'h0000, 0, 0);
        put_desc(32'h1000, 2, 32'hC000, 16'd4,  16'h5000, 0, 0);
        settle();
        chk("R3 nothing fetched before producer write", 64'(q_fetch.size()), 3);
        wr(A_PROD, 32'd24);
        settle();
        rd(A_CONS, v); chk("R4 consumer after three descriptors", v, 24);
        chk_drained("R2");

        // R9 zero count with end-of-block flag
        put_desc(32'h1000, 3, 32'hD000, 16'd0, 16'h2000, 0, 0);
        wr(A_PROD, 32'd32);
        settle();
        rd(A_CONS, v); chk("R9 consumer after zero-count descriptor", v, 32);
        chk_drained("R9");

        // R6 halt and resume
        wr(A_HALT, 32'd1);
        put_desc(32'h1000, 4, 32'hE000, 16'd8, 16'h8000, 0, 0);
        wr(A_PROD, 32'd40);
        settle();
        rd(A_CONS, v); chk("R6 consumer frozen while halted", v, 32);
        chk("R6 no fetch while halted", 64'(q_fetch.size()), 1);
        wr(A_HALT, 32'd0);
        settle();
        rd(A_CONS, v); chk("R6 consumer after resume", v, 40);
        chk_drained("R6");

        // R7 disable and direction
        wr(A_CTRL, 32'h08);
        put_desc(32'h1000, 5, 32'hF000, 16'd12, 16'h4000, 1, 0);
        wr(A_PROD, 32'd48);
        settle();
        rd(A_CONS, v); chk("R7 consumer frozen while disabled", v, 40);
        wr(A_CTRL, 32'h0A);
        settle();
        rd(A_CONS, v); chk("R7 consumer after enable", v, 48);
        chk_drained("R7");

        // R1 pipe reset
        wr(A_RST, 32'd1);
        wr(A_CTRL, 32'h22);
        rd(A_CTRL, v); chk("R1 control write dropped during reset", v, 0);
        wr(A_RST, 32'd0);
        rd(A_CONS, v); chk("R1 consumer after pipe reset", v, 0);
        rd(A_BASE, v); chk("R1 base after pipe reset", v, 0);
        rd(A_PROD, v); chk("R1 producer after pipe reset", v, 0);
        rd(A_SIZE, v); chk("R1 size after pipe reset", v, 32768);

        // R5 wrap with a 32-byte ring
        wr(A_BASE, 32'h2000);
        wr(A_SIZE, 32'd32);
        wr(A_CTRL, 32'h02);
        put_desc(32'h2000, 0, 32'h100, 16'd1, 16'h0000, 0, 0);
        put_desc(32'h2000, 1, 32'h200, 16'd2, 16'h1000, 0, 0);
        put_desc(32'h2000, 2, 32'h300, 16'd3, 16'h0000, 0, 0);
        wr(A_PROD, 32'd24);
        settle();
        rd(A_CONS, v); chk("R5 consumer before wrap", v, 24);
        put_desc(32'h2000, 3, 32'h400, 16'd4, 16'h4000, 0, 0);
        put_desc(32'h2000, 0, 32'h500, 16'd5, 16'h8000, 0, 0);
        wr(A_PROD, 32'd8);
        settle();
        rd(A_CONS, v); chk("R5 consumer after wrap", v, 8);
        chk_drained("R5");

        // R10 mover error
        err_inject = 1;
        put_desc(32'h2000, 1, 32'h600, 16'd6, 16'h8000, 0, 1);
        wr(A_PROD, 32'd16);
        settle();
        err_inject = 0;
        chk("R10 error event held", ev_err, 1);
        rd(A_CONS, v); chk("R10 consumer stays on failing descriptor", v, 8);
        wr(A_PROD, 32'd24);
        settle();
        rd(A_CONS, v); chk("R10 no progress after error", v, 8);
        chk("R10 error still held", ev_err, 1);
        chk_drained("R10");
        wr(A_RST, 32'd1);
        wr(A_RST, 32'd0);
        chk("R10 error cleared by pipe reset", ev_err, 0);
        rd(A_CONS, v); chk("R1 consumer cleared after fault reset", v, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule